// File: doc/BRIEF.md
# CAN Power-Save Mode Sequencer

This block manages the low-power states of a CAN protocol controller. The CPU writes a 2-bit power-save field to request sleep, stop or a return to normal operation. The block decides whether each request is taken or dropped, and it watches the synchronized receive pin so that bus activity can wake it from sleep. It keeps the operating mode that was active when sleep began and hands it back when sleep ends.

After any wake-up, transmit and receive stay blocked until the bus has been idle long enough. The block counts consecutive recessive bits on a bit-time strobe. A wake caused by the bus raises a sticky flag. That flag does not depend on the interrupt enable. The enable only gates the interrupt line that leaves the block.

Top module: `can_psave_ctrl`

## Requirements
- R1: The field readback `ps_state` uses 00 = awake, 01 = sleep, 11 = stop, and it reads 00 after reset. A write of 10 changes nothing. A write of 01 while awake enters sleep.
- R2: A write of 11 enters stop only from sleep. While awake the write is dropped.
- R3: Stop ends only through a write of 01, which leads to sleep. A write of 00 and a receive falling edge both leave stop unchanged.
- R4: `tx_inhibit` and `rx_inhibit` are high whenever `ps_state` is not 00.
- R5: Sleep ends through a write of 00 or a high-to-low change on `rx_in`. The falling edge is seen through two synchronizer stages and a delayed copy, so `ps_state` reads 00 at the third rising clock edge after the pin falls.
- R6: At the moment sleep ends, `resume_mode` presents the `op_mode` value captured when sleep was entered, and `resume_valid` pulses for one cycle.
- R7: `wake_irq` is set when a receive edge ends sleep, even with `irq_en` low. A write of 00 does not set it. `irq_clr` clears it.
- R8: On reset, and on every exit from a power-save state, `bus_ready` is low and both inhibits are high. `bus_ready` rises after 11 consecutive `bit_tick` samples of a recessive (1) receive level. A dominant sample restarts the count.
- R9: `init_req` raises `init_ack` one cycle later only while awake. In sleep or stop the request is dropped.
- R10: If a stop write arrives in the same cycle as a receive edge that ends sleep, the edge takes priority: the block wakes, and stop is not entered.
- R11: `wake_int` is high exactly when `wake_irq` is set and `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_wr | input | 1 | Write strobe for the power-save field |
| ps_wdata | input | 2 | Power-save field value written |
| op_mode | input | MODE_W | Current operating mode of the controller |
| init_req | input | 1 | Request to enter initialization mode |
| irq_en | input | 1 | Enable for the wake-up interrupt line |
| irq_clr | input | 1 | Clears the wake-up flag |
| rx_in | input | 1 | Asynchronous CAN receive pin |
| bit_tick | input | 1 | One pulse per bit time |
| ps_state | output | 2 | Active power-save state |
| wake_irq | output | 1 | Sticky bus wake-up flag |
| wake_int | output | 1 | Gated wake-up interrupt |
| resume_mode | output | MODE_W | Mode to restore after sleep |
| resume_valid | output | 1 | One-cycle pulse when sleep ends |
| init_ack | output | 1 | Initialization request accepted |
| tx_inhibit | output | 1 | Transmission blocked |
| rx_inhibit | output | 1 | Reception blocked |
| bus_ready | output | 1 | Idle-bus rejoin condition met |

## Verification
The hardest case to produce is the collision between a stop write and a bus wake. The falling edge reaches the state machine only after the synchronizer and the delayed copy, so the pin must change two clock edges before the write strobe is driven. The bench times the pin change so that both arrive at the same edge. It then confirms that the block ends up awake with the wake flag set. Stop-state immunity to pin edges is reached by first entering sleep and then stop, then dropping the pin.

// File: rtl/can_psave_pkg.sv
package can_psave_pkg;
  typedef enum logic [1:0] {
    PS_AWAKE = 2'b00,
    PS_SLEEP = 2'b01,
    PS_STOP  = 2'b11
  } ps_state_e;

  localparam logic [1:0] REQ_AWAKE = 2'b00;
  localparam logic [1:0] REQ_SLEEP = 2'b01;
  localparam logic [1:0] REQ_STOP  = 2'b11;
endpackage

// File: rtl/can_psave_rxsync.sv
module can_psave_rxsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rx_s,
  output logic rx_fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], rx_in};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rx_s    = sh_q[STAGES-1];
  assign rx_fall = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/can_psave_fsm.sv
module can_psave_fsm
  import can_psave_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ps_wr,
  input  logic [1:0]        ps_wdata,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              init_req,
  input  logic              irq_clr,
  input  logic              rx_fall,
  output ps_state_e         state_q,
  output logic              save_next,
  output logic              wake_irq,
  output logic [MODE_W-1:0] resume_mode,
  output logic              resume_valid,
  output logic              init_ack
);
  ps_state_e         state_d;
  logic [MODE_W-1:0] mode_q;
  logic              bus_wake;
  logic              sw_wake;

  always_comb begin
    state_d  = state_q;
    bus_wake = 1'b0;
    sw_wake  = 1'b0;
    unique case (state_q)
      PS_AWAKE: if (ps_wr && ps_wdata == REQ_SLEEP) state_d = PS_SLEEP;
      PS_SLEEP: begin
        if (rx_fall) begin
          bus_wake = 1'b1;
          state_d  = PS_AWAKE;
        end else if (ps_wr && ps_wdata == REQ_AWAKE) begin
          sw_wake = 1'b1;
          state_d = PS_AWAKE;
        end else if (ps_wr && ps_wdata == REQ_STOP) begin
          state_d = PS_STOP;
        end
      end
      PS_STOP:  if (ps_wr && ps_wdata == REQ_SLEEP) state_d = PS_SLEEP;
      default:  state_d = PS_AWAKE;
    endcase
  end

  assign save_next = (state_d != PS_AWAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PS_AWAKE;
      mode_q       <= '0;
      wake_irq     <= 1'b0;
      resume_mode  <= '0;
      resume_valid <= 1'b0;
      init_ack     <= 1'b0;
    end else begin
      state_q      <= state_d;
      resume_valid <= bus_wake | sw_wake;
      init_ack     <= init_req && (state_q == PS_AWAKE);
      if (state_q == PS_AWAKE && state_d == PS_SLEEP) mode_q <= op_mode;
      if (bus_wake | sw_wake) resume_mode <= mode_q;
      if (bus_wake)     wake_irq <= 1'b1;
      else if (irq_clr) wake_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/can_psave_idle.sv
module can_psave_idle #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic bit_tick,
  input  logic rx_s,
  output logic bus_ready
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q     <= '0;
      bus_ready <= 1'b0;
    end else if (bit_tick && !bus_ready) begin
      if (!rx_s) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        bus_ready <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_psave_ctrl.sv
module can_psave_ctrl
  import can_psave_pkg::*;
#(
  parameter int MODE_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_BITS   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ps_wr,
  input  logic [1:0]        ps_wdata,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              init_req,
  input  logic              irq_en,
  input  logic              irq_clr,
  input  logic              rx_in,
  input  logic              bit_tick,
  output logic [1:0]        ps_state,
  output logic              wake_irq,
  output logic              wake_int,
  output logic [MODE_W-1:0] resume_mode,
  output logic              resume_valid,
  output logic              init_ack,
  output logic              tx_inhibit,
  output logic              rx_inhibit,
  output logic              bus_ready
);
  logic      rx_s;
  logic      rx_fall;
  logic      save_next;
  ps_state_e state_q;

  can_psave_rxsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rx_in(rx_in), .rx_s(rx_s), .rx_fall(rx_fall)
  );

  can_psave_fsm #(.MODE_W(MODE_W)) u_fsm (
    .clk(clk), .rst(rst), .ps_wr(ps_wr), .ps_wdata(ps_wdata),
    .op_mode(op_mode), .init_req(init_req), .irq_clr(irq_clr),
    .rx_fall(rx_fall), .state_q(state_q), .save_next(save_next),
    .wake_irq(wake_irq), .resume_mode(resume_mode),
    .resume_valid(resume_valid), .init_ack(init_ack)
  );

  can_psave_idle #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst(rst), .hold(save_next), .bit_tick(bit_tick),
    .rx_s(rx_s), .bus_ready(bus_ready)
  );

  assign ps_state   = state_q;
  assign wake_int   = wake_irq & irq_en;
  assign tx_inhibit = ~bus_ready;
  assign rx_inhibit = ~bus_ready;
endmodule

// File: rtl/can_psave_ctrl_chk.sv
module can_psave_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ps_state,
  input logic       wake_irq,
  input logic       init_ack,
  input logic       tx_inhibit,
  input logic       rx_inhibit,
  input logic       bus_ready,
  input logic       bit_tick
);
  p_stop_from_sleep_r2: assert property (@(posedge clk) disable iff (rst)
    (ps_state == 2'b11 && $past(ps_state) != 2'b11) |-> $past(ps_state) == 2'b01);

  p_stop_exit_sleep_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(ps_state) == 2'b11 && ps_state != 2'b11) |-> ps_state == 2'b01);

  p_inhibit_in_save_r4: assert property (@(posedge clk) disable iff (rst)
    (ps_state != 2'b00) |-> (tx_inhibit && rx_inhibit && !bus_ready));

  p_bus_wake_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_irq) |-> (ps_state == 2'b00 && $past(ps_state) == 2'b01));

  p_ready_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ready) |-> $past(bit_tick));

  p_no_init_in_save_r9: assert property (@(posedge clk) disable iff (rst)
    init_ack |-> $past(ps_state) == 2'b00);
endmodule

bind can_psave_ctrl can_psave_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .ps_state(ps_state), .wake_irq(wake_irq),
  .init_ack(init_ack), .tx_inhibit(tx_inhibit), .rx_inhibit(rx_inhibit),
  .bus_ready(bus_ready), .bit_tick(bit_tick)
);

// File: tb/can_psave_ctrl_test.sv
module can_psave_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ps_wr = 1'b0;
  logic [1:0] ps_wdata = 2'b00;
  logic [1:0] op_mode = 2'b00;
  logic       init_req = 1'b0;
  logic       irq_en = 1'b0;
  logic       irq_clr = 1'b0;
  logic       rx_in = 1'b1;
  logic       bit_tick = 1'b0;
  logic [1:0] ps_state;
  logic       wake_irq, wake_int, resume_valid, init_ack;
  logic       tx_inhibit, rx_inhibit, bus_ready;
  logic [1:0] resume_mode;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  can_psave_ctrl uut (
    .clk(clk), .rst(rst), .ps_wr(ps_wr), .ps_wdata(ps_wdata),
    .op_mode(op_mode), .init_req(init_req), .irq_en(irq_en),
    .irq_clr(irq_clr), .rx_in(rx_in), .bit_tick(bit_tick),
    .ps_state(ps_state), .wake_irq(wake_irq), .wake_int(wake_int),
    .resume_mode(resume_mode), .resume_valid(resume_valid),
    .init_ack(init_ack), .tx_inhibit(tx_inhibit), .rx_inhibit(rx_inhibit),
    .bus_ready(bus_ready)
  );

  // vector: {wr, data[1:0], rx, expected ps_state[1:0]}
  localparam int NV = 9;
  localparam logic [5:0] VECS [NV] = '{
    {1'b1, 2'b11, 1'b1, 2'b00},  // R2 stop dropped while awake
    {1'b1, 2'b01, 1'b1, 2'b01},  // R1 sleep entered
    {1'b1, 2'b10, 1'b1, 2'b01},  // R1 code 10 no effect
    {1'b1, 2'b11, 1'b1, 2'b11},  // R2 stop from sleep
    {1'b1, 2'b00, 1'b0, 2'b11},  // R3 edge and 00 ignored in stop
    {1'b1, 2'b01, 1'b0, 2'b01},  // R3 stop back to sleep
    {1'b1, 2'b00, 1'b1, 2'b00},  // R5 software wake
    {1'b1, 2'b01, 1'b1, 2'b01},  // R1 sleep again
    {1'b0, 2'b00, 1'b0, 2'b00}   // R5 bus edge wake
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_in = 1'b1; ps_wr = 1'b0; bit_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_ps(input logic [1:0] v);
    @(negedge clk);
    ps_wr = 1'b1; ps_wdata = v;
    @(negedge clk);
    ps_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check(ps_state == 2'b00, "R1 reset state", ps_state, 0);
    check(tx_inhibit && rx_inhibit && !bus_ready, "R8 reset inhibit", bus_ready, 0);
    check(!wake_irq, "R7 reset flag", wake_irq, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ps_wr = VECS[i][5]; ps_wdata = VECS[i][4:3]; rx_in = VECS[i][2];
      @(negedge clk);
      ps_wr = 1'b0;
      repeat (4) @(negedge clk);
      check(ps_state == VECS[i][1:0], "R1/R2/R3/R5 vector table", ps_state, VECS[i][1:0]);
      if (ps_state != 2'b00)
        check(tx_inhibit && rx_inhibit, "R4 inhibit in power save", tx_inhibit, 1);
    end
    check(wake_irq == 1'b1, "R7 flag set with irq_en low", wake_irq, 1);
    check(wake_int == 1'b0, "R11 line gated off", wake_int, 0);
    irq_en = 1'b1;
    @(negedge clk);
    check(wake_int == 1'b1, "R11 line follows enable", wake_int, 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check(wake_irq == 1'b0, "R7 flag cleared", wake_irq, 0);

    // R5 exact latency: third rising edge after pin falls
    rx_in = 1'b1;
    write_ps(2'b01);
    @(negedge clk);
    rx_in = 1'b0;
    repeat (2) @(negedge clk);
    check(ps_state == 2'b01, "R5 still asleep after two edges", ps_state, 1);
    @(negedge clk);
    check(ps_state == 2'b00, "R5 awake at third edge", ps_state, 0);
    check(resume_valid == 1'b1, "R6 resume pulse", resume_valid, 1);
    @(negedge clk);
    check(resume_valid == 1'b0, "R6 pulse one cycle", resume_valid, 0);

    // R6 mode restore across software wake
    rx_in = 1'b1;
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    op_mode = 2'b10;
    write_ps(2'b01);
    op_mode = 2'b01;
    write_ps(2'b00);
    check(resume_mode == 2'b10, "R6 captured mode", resume_mode, 2);
    check(wake_irq == 1'b0, "R7 software wake leaves flag", wake_irq, 0);

    // R9 init requests
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    check(init_ack == 1'b1, "R9 init accepted awake", init_ack, 1);
    write_ps(2'b01);
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    check(init_ack == 1'b0, "R9 init dropped in sleep", init_ack, 0);
    check(ps_state == 2'b01, "R9 still asleep", ps_state, 1);

    // R10 stop write colliding with bus edge
    @(negedge clk);
    rx_in = 1'b0;
    repeat (2) @(negedge clk);
    ps_wr = 1'b1; ps_wdata = 2'b11;
    @(negedge clk);
    ps_wr = 1'b0;
    repeat (3) @(negedge clk);
    check(ps_state == 2'b00, "R10 edge wins over stop", ps_state, 0);
    check(wake_irq == 1'b1, "R10 bus wake flag", wake_irq, 1);

    // R8 idle counting
    rx_in = 1'b1;
    repeat (3) @(negedge clk);
    repeat (10) tick();
    check(bus_ready == 1'b0, "R8 not ready after 10", bus_ready, 0);
    check(tx_inhibit == 1'b1, "R8 tx blocked before rejoin", tx_inhibit, 1);
    tick();
    check(bus_ready == 1'b1, "R8 ready after 11", bus_ready, 1);
    check(!tx_inhibit && !rx_inhibit, "R8 inhibits released", tx_inhibit, 0);

    // R8 dominant sample restarts count
    write_ps(2'b01);
    check(bus_ready == 1'b0, "R8 ready cleared in sleep", bus_ready, 0);
    write_ps(2'b00);
    repeat (5) tick();
    rx_in = 1'b0;
    repeat (3) @(negedge clk);
    tick();
    rx_in = 1'b1;
    repeat (3) @(negedge clk);
    repeat (10) tick();
    check(bus_ready == 1'b0, "R8 count restarted", bus_ready, 0);
    tick();
    check(bus_ready == 1'b1, "R8 ready after restart", bus_ready, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule